// File: doc/BRIEF.md
# Triggered Multichannel Waveform Recorder

The block records a burst of samples from eight parallel 10-bit converter channels when an external start pulse arrives. While idle it waits for the start input. The clock edge that sees the start input high stores the first sample of every channel. After that it stores one sample per channel on each clock edge, 10 ns apart at 100 MHz, until every channel holds a fixed-length record. The converter's over-range flag is stored beside each code.

When the record is complete the block raises a request to the host. The host drives an accept line. On every clock edge where the request and accept are both high, one stored sample leaves the block. It appears on a 32-bit output port one cycle later, framed by a valid strobe. Each word carries the code, the over-range flag, the channel number, the sample index and a parity bit, so the host can place it and check it without any side channel. After the last word the request drops and the block waits for the next start.

Top module: `wavecap_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_o` and `valid_o` are 0 and `data_o` is all zeros.
- R2: With the block idle, the clock edge that samples `trig_i` high stores the converter inputs as sample 0 of every channel. Each following edge stores the next sample index, with no gaps, and `req_o` stays low throughout the capture.
- R3: Each channel's over-range input is captured on the same edge as its code and is returned with that sample.
- R4: `req_o` rises on the edge that stores sample 1023 and becomes visible the cycle after it. No word is output until the host accepts, however long accept stays low.
- R5: The word layout is bits [9:0] ADC code, bit 10 over-range flag, bits [13:11] channel number, bits [23:14] sample index and bit 24 parity.
- R6: Bit 24 makes the number of ones in bits [24:0] even.
- R7: Words leave channel by channel from 0 to 7. Within a channel, sample indices run from 0 to 1023.
- R8: Each clock edge with `req_o` and `accept_i` both high sends exactly one word, and `valid_o` is high in the following cycle. When accept is low at an edge, `valid_o` is low in the following cycle and the read position holds.
- R9: A `trig_i` pulse during capture or during readout is ignored. The stored record and the readout sequence stay unchanged.
- R10: `req_o` drops in the same cycle that the last word (channel 7, sample 1023) is shown on the port. The block is then idle and a new trigger starts a new capture.
- R11: Whenever `valid_o` is low, `data_o` is zero. Bits [31:25] are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling and transfer clock (100 MHz) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Start pulse, honoured only while idle |
| adc_code_i | input | 80 | Converter codes, channel c in bits [10c+9:10c] |
| adc_ovr_i | input | 8 | Over-range flags, bit c for channel c |
| accept_i | input | 1 | Host accepts one word per edge while high |
| req_o | output | 1 | Record ready, transfer pending or running |
| valid_o | output | 1 | `data_o` holds a word this cycle |
| data_o | output | 32 | Tagged sample word |

## Verification
A sample driven before an edge is stored at that edge. The request appears one cycle after the edge that stores the last sample. A word sent at an edge shows on the port for exactly the following cycle. The bench drives inputs on falling edges and reads the outputs there, before it changes anything. It keeps a one-cycle record of whether the previous rising edge sent a word, so `valid_o` is judged against that record and not against the current accept value. The request is checked in the cycle after sample 1023 is stored. The release of the request is checked in the same cycle that the final word is compared.

// File: rtl/wavecap_pkg.sv
package wavecap_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_CAPTURE = 2'd1,
      ST_SEND    = 2'd2
   } cap_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/wavecap_capture_ctrl.sv
module wavecap_capture_ctrl
   import wavecap_pkg::*;
#(
   parameter int DEPTH = 1024,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          trig_i,
   input  logic          last_fire_i,
   output cap_state_e    state_o,
   output logic          wr_en_o,
   output logic [AW-1:0] wr_addr_o
);

   cap_state_e    state_q;
   logic [AW-1:0] cnt_q;

   // the edge that sees the trigger stores sample 0; later edges follow the counter
   always_comb begin
      wr_en_o   = ((state_q == ST_IDLE) && trig_i) || (state_q == ST_CAPTURE);
      wr_addr_o = (state_q == ST_CAPTURE) ? cnt_q : '0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (trig_i) begin
                  state_q <= ST_CAPTURE;
                  cnt_q   <= AW'(1);
               end
            end
            ST_CAPTURE: begin
               if (cnt_q == AW'(DEPTH - 1)) begin
                  state_q <= ST_SEND;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + AW'(1);
               end
            end
            ST_SEND: begin
               if (last_fire_i) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/wavecap_chan_store.sv
module wavecap_chan_store #(
   parameter int DW    = 11,
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk_i,
   input  logic          wr_en_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          rd_en_i,
   input  logic [AW-1:0] rd_addr_i,
   output logic [DW-1:0] rd_q_o
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk_i) begin
      if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
      if (rd_en_i) rd_q_o <= mem[rd_addr_i];
   end

endmodule

// File: rtl/wavecap_readout_seq.sv
module wavecap_readout_seq #(
   parameter int NUM_CH = 8,
   parameter int DEPTH  = 1024,
   localparam int CW    = $clog2(NUM_CH),
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          send_i,
   input  logic          accept_i,
   output logic          fire_o,
   output logic          last_fire_o,
   output logic [CW-1:0] rd_ch_o,
   output logic [AW-1:0] rd_idx_o,
   output logic          tag_vld_o,
   output logic [CW-1:0] tag_ch_o,
   output logic [AW-1:0] tag_idx_o
);

   logic [CW-1:0] ch_q;
   logic [AW-1:0] idx_q;
   logic          idx_wrap;
   logic          ch_wrap;

   assign fire_o      = send_i && accept_i;
   assign idx_wrap    = (idx_q == AW'(DEPTH - 1));
   assign ch_wrap     = (ch_q == CW'(NUM_CH - 1));
   assign last_fire_o = fire_o && idx_wrap && ch_wrap;
   assign rd_ch_o     = ch_q;
   assign rd_idx_o    = idx_q;

   // channel-major walk over the record
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ch_q  <= '0;
         idx_q <= '0;
      end else if (!send_i) begin
         ch_q  <= '0;
         idx_q <= '0;
      end else if (fire_o) begin
         if (idx_wrap) begin
            idx_q <= '0;
            ch_q  <= ch_wrap ? '0 : ch_q + CW'(1);
         end else begin
            idx_q <= idx_q + AW'(1);
         end
      end
   end

   // tags travel alongside the synchronous memory read
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tag_vld_o <= 1'b0;
         tag_ch_o  <= '0;
         tag_idx_o <= '0;
      end else begin
         tag_vld_o <= fire_o;
         if (fire_o) begin
            tag_ch_o  <= ch_q;
            tag_idx_o <= idx_q;
         end
      end
   end

endmodule

// File: rtl/wavecap_word_fmt.sv
module wavecap_word_fmt #(
   parameter int SW    = 10,
   parameter int CW    = 3,
   parameter int IW    = 10,
   parameter int OUT_W = 32,
   localparam int BODY_W = SW + 1 + CW + IW,
   localparam int WORD_W = BODY_W + 1
) (
   input  logic             vld_i,
   input  logic [SW-1:0]    code_i,
   input  logic             ovr_i,
   input  logic [CW-1:0]    ch_i,
   input  logic [IW-1:0]    idx_i,
   output logic [OUT_W-1:0] word_o
);

   logic [BODY_W-1:0] body;
   logic              par;
   logic [WORD_W-1:0] framed;

   assign body   = {idx_i, ch_i, ovr_i, code_i};
   assign par    = ^body;
   assign framed = {par, body};

   generate
      if (OUT_W > WORD_W) begin : g_pad
         assign word_o = vld_i ? {{(OUT_W - WORD_W){1'b0}}, framed} : '0;
      end else begin : g_exact
         assign word_o = vld_i ? framed : '0;
      end
   endgenerate

endmodule

// File: rtl/wavecap_top.sv
module wavecap_top
   import wavecap_pkg::*;
#(
   parameter int NUM_CH  = 8,
   parameter int SW      = 10,
   parameter int DEPTH   = 1024,
   parameter int OUT_W   = 32,
   parameter bit RD_GATE = 1'b1,
   localparam int CW     = $clog2(NUM_CH),
   localparam int AW     = $clog2(DEPTH),
   localparam int DW     = SW + 1,
   localparam int WORD_W = SW + 1 + CW + AW + 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 trig_i,
   input  logic [NUM_CH*SW-1:0] adc_code_i,
   input  logic [NUM_CH-1:0]    adc_ovr_i,
   input  logic                 accept_i,
   output logic                 req_o,
   output logic                 valid_o,
   output logic [OUT_W-1:0]     data_o
);

   generate
      if (!is_pow2(NUM_CH) || NUM_CH < 2) begin : g_bad_ch
         $error("NUM_CH must be a power of two of at least 2");
      end
      if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (WORD_W > OUT_W) begin : g_bad_width
         $error("tagged word does not fit the output port");
      end
   endgenerate

   cap_state_e    state;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic          fire;
   logic          last_fire;
   logic [CW-1:0] rd_ch;
   logic [AW-1:0] rd_idx;
   logic          tag_vld;
   logic [CW-1:0] tag_ch;
   logic [AW-1:0] tag_idx;
   logic [DW-1:0] bank_q [NUM_CH];
   logic [DW-1:0] sel_q;

   wavecap_capture_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .trig_i      (trig_i),
      .last_fire_i (last_fire),
      .state_o     (state),
      .wr_en_o     (wr_en),
      .wr_addr_o   (wr_addr)
   );

   wavecap_readout_seq #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .send_i      (state == ST_SEND),
      .accept_i    (accept_i),
      .fire_o      (fire),
      .last_fire_o (last_fire),
      .rd_ch_o     (rd_ch),
      .rd_idx_o    (rd_idx),
      .tag_vld_o   (tag_vld),
      .tag_ch_o    (tag_ch),
      .tag_idx_o   (tag_idx)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
         logic rd_en;
         if (RD_GATE) begin : g_gated
            // only the bank being drained is read
            assign rd_en = fire && (rd_ch == CW'(c));
         end else begin : g_broad
            assign rd_en = fire;
         end
         wavecap_chan_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
            .clk_i     (clk_i),
            .wr_en_i   (wr_en),
            .wr_addr_i (wr_addr),
            .wr_data_i ({adc_ovr_i[c], adc_code_i[c*SW +: SW]}),
            .rd_en_i   (rd_en),
            .rd_addr_i (rd_idx),
            .rd_q_o    (bank_q[c])
         );
      end
   endgenerate

   assign sel_q = bank_q[tag_ch];

   wavecap_word_fmt #(.SW(SW), .CW(CW), .IW(AW), .OUT_W(OUT_W)) u_fmt (
      .vld_i  (tag_vld),
      .code_i (sel_q[SW-1:0]),
      .ovr_i  (sel_q[SW]),
      .ch_i   (tag_ch),
      .idx_i  (tag_idx),
      .word_o (data_o)
   );

   assign req_o   = (state == ST_SEND);
   assign valid_o = tag_vld;

endmodule

// File: rtl/wavecap_checker.sv
module wavecap_checker #(
   parameter int OUT_W  = 32,
   parameter int WORD_W = 25
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             trig_i,
   input logic             accept_i,
   input logic             req_o,
   input logic             valid_o,
   input logic [OUT_W-1:0] data_o
);

   // R8
   valid_needs_send_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> $past(req_o && accept_i));

   // R8
   send_gives_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && accept_i) |=> valid_o);

   // R4
   req_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && !accept_i) |=> req_o);

   // R10
   last_word_on_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(req_o) |-> valid_o);

   // R9
   trig_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && trig_i) |=> (req_o || valid_o));

   // R6
   parity_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (^data_o[WORD_W-1:0] == 1'b0));

   // R11
   quiet_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o |-> (data_o == '0));

   generate
      if (OUT_W > WORD_W) begin : g_upper
         // R11
         upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            data_o[OUT_W-1:WORD_W] == '0);
      end
   endgenerate

endmodule

bind wavecap_top wavecap_checker #(.OUT_W(OUT_W), .WORD_W(WORD_W)) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .trig_i   (trig_i),
   .accept_i (accept_i),
   .req_o    (req_o),
   .valid_o  (valid_o),
   .data_o   (data_o)
);

// File: tb/wavecap_top_bench.sv
`timescale 1ns/1ps
module wavecap_top_bench;

   localparam int NUM_CH = 8;
   localparam int SW     = 10;
   localparam int DEPTH  = 1024;
   localparam int OUT_W  = 32;
   localparam int TOTAL  = NUM_CH * DEPTH;

   logic                 clk = 1'b0;
   logic                 rst_n;
   logic                 trig;
   logic [NUM_CH*SW-1:0] adc_code;
   logic [NUM_CH-1:0]    adc_ovr;
   logic                 accept;
   logic                 req;
   logic                 valid;
   logic [OUT_W-1:0]     data;

   int checks = 0;
   int errors = 0;
   logic [10:0] exp_mem [NUM_CH][DEPTH];

   always #5 clk = ~clk;

   wavecap_top u_wavecap_top (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .trig_i     (trig),
      .adc_code_i (adc_code),
      .adc_ovr_i  (adc_ovr),
      .accept_i   (accept),
      .req_o      (req),
      .valid_o    (valid),
      .data_o     (data)
   );

   function automatic logic [31:0] exp_word(input int ch, input int idx, input logic [10:0] s);
      logic [23:0] b;
      b = {idx[9:0], ch[2:0], s[10], s[9:0]};
      return {7'b0, ^b, b};
   endfunction

   function automatic logic [10:0] gen_sample(input int mode, input int ch, input int idx);
      case (mode)
         0:       return 11'($urandom);
         1:       return ((idx + ch) % 2 == 0) ? 11'h7FF : 11'h000;
         default: return {idx == DEPTH - 1, 10'((idx * 7 + ch * 131) & 1023)};
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive_sample(input int mode, input int idx);
      for (int c = 0; c < NUM_CH; c++) begin
         logic [10:0] s;
         s = gen_sample(mode, c, idx);
         exp_mem[c][idx] = s;
         adc_code[c*SW +: SW] = s[9:0];
         adc_ovr[c] = s[10];
      end
   endtask

   task automatic do_capture(input int mode, input bit retrig);
      @(negedge clk);
      drive_sample(mode, 0);
      trig = 1'b1;
      for (int i = 1; i < DEPTH; i++) begin
         @(negedge clk);
         if (i == 1 || i == DEPTH - 1)
            check(req == 1'b0, "R2 no request during capture", 32'(req), 32'd0);
         trig = (retrig && (i == 300 || i == 301)) ? 1'b1 : 1'b0;
         drive_sample(mode, i);
      end
      @(negedge clk);
      trig = 1'b0;
      check(req == 1'b1, "R4 request after last sample", 32'(req), 32'd1);
      check(valid == 1'b0, "R4 no word before accept", 32'(valid), 32'd0);
   endtask

   task automatic do_readout(input int pct, input int hold);
      int  got = 0;
      int  ech = 0;
      int  eidx = 0;
      bit  pend = 0;
      for (int h = 0; h < hold; h++) begin
         accept = 1'b0;
         @(negedge clk);
         check(valid == 1'b0 && req == 1'b1, "R4 waits for accept", {30'd0, req, valid}, 32'd2);
      end
      while (got < TOTAL) begin
         @(negedge clk);
         check(valid == pend, "R8 valid follows accepted edge", 32'(valid), 32'(pend));
         if (valid) begin
            logic [31:0] e;
            e = exp_word(ech, eidx, exp_mem[ech][eidx]);
            check(data == e, "R3 R5 R7 R9 word content", data, e);
            check(^data[24:0] == 1'b0, "R6 even parity", data, e);
            got++;
            if (eidx == DEPTH - 1) begin
               eidx = 0;
               ech++;
            end else begin
               eidx++;
            end
         end else begin
            check(data == '0, "R11 idle bus zero", data, 32'd0);
         end
         if (got == TOTAL) begin
            check(req == 1'b0, "R10 request released with last word", 32'(req), 32'd0);
         end else begin
            accept = ($urandom_range(99) < pct);
            trig   = ($urandom_range(9) == 0);
            pend   = req && accept;
         end
      end
      accept = 1'b0;
      trig   = 1'b0;
      @(negedge clk);
      check(valid == 1'b0 && data == '0 && req == 1'b0, "R10 idle after readout",
            data | {30'd0, req, valid}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      rst_n    = 1'b0;
      trig     = 1'b0;
      accept   = 1'b0;
      adc_code = '0;
      adc_ovr  = '0;
      repeat (3) @(negedge clk);
      check(req == 0 && valid == 0 && data == '0, "R1 reset state", data | {30'd0, req, valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req == 0 && valid == 0 && data == '0, "R1 after reset", data | {30'd0, req, valid}, 32'd0);

      // random data, a retrigger mid-capture, patchy accept
      do_capture(0, 1'b1);
      do_readout(75, 6);
      // full-scale / zero alternation with over-range, accept held high
      do_capture(1, 1'b0);
      do_readout(100, 0);
      // ramp with over-range on the final sample, sparse accept
      do_capture(2, 1'b1);
      do_readout(40, 3);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule